// File: doc/BRIEF.md
# Programmable Down-Counter Channel

This block is one 16-bit down-counter channel with a gate input and a single output line. Software selects one of six timing behaviours through a 3-bit mode field and chooses binary or four-decade BCD counting. It then supplies an initial count. The behaviours are: a terminal-count flag, a retriggerable one-shot, a rate generator, a square wave, a strobe started by the count write, and a strobe started by the gate. Each rising edge of `clk` is one count clock.

A surrounding bus unit does the byte assembly and the address decoding. It presents a one-cycle `ctrl_wr` strobe together with the mode and format fields. Separately, it presents a one-cycle `cnt_wr` strobe with the 16-bit initial count already assembled. The live counter value is exposed on `count`, so that unit can latch it whenever it chooses.

A gate rising edge means `gate` was sampled low at one clock edge and high at the next. The trigger acts at that second edge.

Top module: `pcc_channel`

## Requirements
- R1: After synchronous reset, `out` is 0 and `count` is 0.
- R2: In mode 0, a control write drives `out` low. A count write of N puts N on `count` at that edge, and the count then decrements once per clock from the next edge. `out` rises at the edge where the count reaches 0, N clocks after the load edge. `out` then stays high while the count wraps to 0xFFFF and keeps decrementing.
- R3: In modes 0 and 4, while `gate` is low the count holds, and decrementing resumes when `gate` returns high.
- R4: In mode 0, a count write during a countdown reloads the new value and drives `out` low again.
- R5: In mode 1, `out` is high after the control write. A gate rising edge loads N and drives `out` low for exactly N clocks. A further rising edge during the pulse restarts the full N-clock pulse. A rising edge before any count write is ignored.
- R6: In mode 1, a count written during a pulse leaves that pulse and its count unchanged. The next trigger uses the new value.
- R7: In mode 2 (N at least 2), the count runs N down to 1 and then reloads N, and `out` is low exactly while the count is 1. `gate` low holds the count and forces `out` high. A gate rising edge reloads N. A count written while running takes effect at the next reload.
- R8: In mode 3 (N at least 2), the count runs like mode 2. `out` is high for ceil(N/2) clocks and low for floor(N/2) clocks of each N-clock period.
- R9: In mode 4, `out` is high after the count write. It goes low for exactly one clock when the count reaches 0, N clocks after the load, and stays high after that even when the count wraps.
- R10: In mode 5, `out` stays high until a gate rising edge loads N. N clocks after that trigger, `out` goes low for exactly one clock.
- R11: Mode codes 6 and 7 behave exactly as modes 2 and 3.
- R12: With `ctrl_bcd` set, the count decrements as four decimal digits, each 4 bits with the least significant digit in bits 3:0. Examples: 0x0010 becomes 0x0009, 0x1000 becomes 0x0999, and 0x0000 becomes 0x9999.
- R13: In binary format an initial count of 0 acts as 65536: its first decrement gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Count clock; every rising edge is one count |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | One-cycle strobe: take mode and format fields |
| ctrl_mode | input | 3 | Mode code 0..7 (6 and 7 alias 2 and 3) |
| ctrl_bcd | input | 1 | 1 selects BCD counting, 0 binary |
| cnt_wr | input | 1 | One-cycle strobe: take the initial count |
| cnt_val | input | 16 | Initial count value |
| gate | input | 1 | Gate: enable level or trigger edge depending on mode |
| out | output | 1 | Channel output line |
| count | output | 16 | Live counter value |

## Verification
The bench sweeps small counts in every mode and checks `out` and `count` cycle by cycle against arithmetic formulas. These sweeps would expose an off-by-one load or terminal edge, since the pulse or period would come out one clock long or short. The odd-count square wave catches a design that puts the extra clock in the low phase. The retrigger and mid-pulse-write cases catch a one-shot that ignores the retrigger or picks up the new count too early. Further directed cases cover a gate that fails to suspend or to reload, aliases 6 and 7 decoded as different modes, a BCD borrow that falls into hexadecimal digits, and a zero count that stops instead of wrapping.

// File: rtl/pcc_pkg.sv
// Shared types and arithmetic for the counter channel.
// Assumes BCD operands hold only digits 0..9 in every nibble.
package pcc_pkg;
    localparam int CNT_W  = 16;
    localparam int DIGITS = CNT_W / 4;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [2:0] {
        M_TCOUNT   = 3'd0,
        M_ONESHOT  = 3'd1,
        M_RATE     = 3'd2,
        M_SQUARE   = 3'd3,
        M_SWSTROBE = 3'd4,
        M_HWSTROBE = 3'd5
    } mode_e;

    // One step down, binary or per-decade BCD with borrow chain.
    function automatic cnt_t step_down(cnt_t v, logic bcd);
        cnt_t r;
        logic borrow;
        if (!bcd) return v - cnt_t'(1);
        r = v;
        borrow = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (borrow) begin
                if (v[i*4 +: 4] == 4'd0) r[i*4 +: 4] = 4'd9;
                else begin
                    r[i*4 +: 4] = v[i*4 +: 4] - 4'd1;
                    borrow = 1'b0;
                end
            end
        end
        return r;
    endfunction

    // Floor of half the value; zero stands for the full range.
    function automatic cnt_t half_of(cnt_t v, logic bcd);
        cnt_t r;
        logic odd;
        if (v == '0) return bcd ? (cnt_t'(5) << (CNT_W-4)) : (cnt_t'(1) << (CNT_W-1));
        if (!bcd) return v >> 1;
        r = '0;
        odd = 1'b0;
        for (int i = DIGITS-1; i >= 0; i--) begin
            r[i*4 +: 4] = {1'b0, v[i*4+1 +: 3]} + (odd ? 4'd5 : 4'd0);
            odd = v[i*4];
        end
        return r;
    endfunction

    // Codes 6 and 7 drop their top bit and become 2 and 3.
    function automatic mode_e fold_mode(logic [2:0] m);
        return m[1] ? mode_e'({1'b0, m[1:0]}) : mode_e'(m);
    endfunction
endpackage

// File: rtl/pcc_gate_edge.sv
// Gate rising-edge detector: flags an edge sampled low then high.
// Assumes gate is already synchronous to clk. Resets as "was high" so a
// gate held high through reset is not taken as a trigger.
module pcc_gate_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic gate,
    output logic rise
);
    logic gate_q;

    // Remember the gate level at the previous edge.
    always_ff @(posedge clk) begin
        if (!rst_n) gate_q <= 1'b1;
        else        gate_q <= gate;
    end

    assign rise = gate & ~gate_q;
endmodule

// File: rtl/pcc_counter.sv
// Counter register: loads a value or steps down in binary or BCD.
// Assumes ld and dec come from the mode controller; ld wins.
module pcc_counter
    import pcc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld,
    input  cnt_t ld_val,
    input  logic dec,
    input  logic bcd,
    output cnt_t cnt
);
    // Hold, load or decrement the live count.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (ld)  cnt <= ld_val;
        else if (dec) cnt <= step_down(cnt, bcd);
    end
endmodule

// File: rtl/pcc_control.sv
// Mode controller: decodes the six behaviours, decides load and
// decrement for the counter and drives the registered output line.
// Assumes ctrl_wr and cnt_wr are one-cycle strobes; ctrl_wr wins.
module pcc_control
    import pcc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic [2:0] ctrl_mode,
    input  logic       ctrl_bcd,
    input  logic       cnt_wr,
    input  cnt_t       cnt_val,
    input  logic       gate,
    input  logic       rise,
    input  cnt_t       cnt,
    output logic       ld,
    output cnt_t       ld_val,
    output logic       dec,
    output logic       bcd,
    output logic       out
);
    mode_e mode_r, mode_nxt;
    logic  bcd_r, bcd_nxt, have_r, have_nxt, run_r, run_nxt;
    logic  fired_r, fired_nxt, out_r, out_nxt;
    cnt_t  init_r, init_nxt, nxt_per;
    logic  term;

    assign term = (cnt == cnt_t'(1));

    // Next-state and counter commands for the selected mode.
    always_comb begin
        mode_nxt  = mode_r;
        bcd_nxt   = bcd_r;
        have_nxt  = have_r;
        run_nxt   = run_r;
        fired_nxt = fired_r;
        out_nxt   = out_r;
        init_nxt  = init_r;
        ld        = 1'b0;
        ld_val    = init_r;
        dec       = 1'b0;
        nxt_per   = term ? init_r : step_down(cnt, bcd_r);
        if (ctrl_wr) begin
            mode_nxt  = fold_mode(ctrl_mode);
            bcd_nxt   = ctrl_bcd;
            have_nxt  = 1'b0;
            run_nxt   = 1'b0;
            fired_nxt = 1'b0;
            out_nxt   = (fold_mode(ctrl_mode) != M_TCOUNT);
        end else begin
            if (cnt_wr) begin
                init_nxt = cnt_val;
                have_nxt = 1'b1;
            end
            case (mode_r)
                M_TCOUNT, M_SWSTROBE: begin
                    if (cnt_wr) begin
                        ld        = 1'b1;
                        ld_val    = cnt_val;
                        run_nxt   = 1'b1;
                        fired_nxt = 1'b0;
                        out_nxt   = (mode_r == M_SWSTROBE);
                    end else begin
                        if (mode_r == M_SWSTROBE) out_nxt = 1'b1;
                        if (run_r && gate) begin
                            dec = 1'b1;
                            if (term && mode_r == M_TCOUNT) out_nxt = 1'b1;
                            if (term && mode_r == M_SWSTROBE && !fired_r) begin
                                out_nxt   = 1'b0;
                                fired_nxt = 1'b1;
                            end
                        end
                    end
                end
                M_ONESHOT, M_HWSTROBE: begin
                    if (mode_r == M_HWSTROBE) out_nxt = 1'b1;
                    if (rise && have_r) begin
                        ld        = 1'b1;
                        run_nxt   = 1'b1;
                        fired_nxt = 1'b0;
                        out_nxt   = (mode_r == M_HWSTROBE);
                    end else if (run_r) begin
                        dec = 1'b1;
                        if (term && !fired_r) begin
                            fired_nxt = 1'b1;
                            out_nxt   = (mode_r == M_ONESHOT);
                        end
                    end
                end
                M_RATE, M_SQUARE: begin
                    if (cnt_wr && !run_r) begin
                        ld      = 1'b1;
                        ld_val  = cnt_val;
                        run_nxt = 1'b1;
                        out_nxt = 1'b1;
                    end else if (!gate) begin
                        out_nxt = 1'b1;
                    end else if (rise && run_r) begin
                        ld      = 1'b1;
                        out_nxt = 1'b1;
                    end else if (run_r) begin
                        ld  = term;
                        dec = !term;
                        if (mode_r == M_RATE) out_nxt = (nxt_per != cnt_t'(1));
                        else out_nxt = (nxt_per == '0) || (nxt_per > half_of(init_r, bcd_r));
                    end
                end
                default: ;
            endcase
        end
    end

    // Register mode, format, initial count, flags and the output line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_r  <= M_TCOUNT;
            bcd_r   <= 1'b0;
            have_r  <= 1'b0;
            run_r   <= 1'b0;
            fired_r <= 1'b0;
            out_r   <= 1'b0;
            init_r  <= '0;
        end else begin
            mode_r  <= mode_nxt;
            bcd_r   <= bcd_nxt;
            have_r  <= have_nxt;
            run_r   <= run_nxt;
            fired_r <= fired_nxt;
            out_r   <= out_nxt;
            init_r  <= init_nxt;
        end
    end

    assign bcd = bcd_r;
    assign out = out_r;

    AST_M0_RISE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == M_TCOUNT && $rose(out_r)) |-> (cnt == '0)); // R2
    AST_HOLD_GATE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_r == M_TCOUNT || mode_r == M_SWSTROBE) && run_r && !gate && !ctrl_wr && !cnt_wr)
        |=> $stable(cnt)); // R3
    AST_RATE_LOW_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == M_RATE && !out_r && !ctrl_wr && !cnt_wr && init_r != cnt_t'(1)) |=> out_r); // R7
    AST_SW_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == M_SWSTROBE && !out_r && !ctrl_wr) |=> out_r); // R9
    AST_HW_STROBE_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_r == M_HWSTROBE && !out_r && !ctrl_wr) |=> out_r); // R10
endmodule

// File: rtl/pcc_channel.sv
// Top of one programmable down-counter channel. Connects the gate edge
// detector, the mode controller and the counter register.
// Assumes all inputs are synchronous to clk; one clk edge is one count.
module pcc_channel
    import pcc_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic [2:0]       ctrl_mode,
    input  logic             ctrl_bcd,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             gate,
    output logic             out,
    output logic [CNT_W-1:0] count
);
    logic rise, ld, dec, bcd;
    cnt_t ld_val, cnt;

    pcc_gate_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .gate  (gate),
        .rise  (rise)
    );

    pcc_control u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_mode (ctrl_mode),
        .ctrl_bcd  (ctrl_bcd),
        .cnt_wr    (cnt_wr),
        .cnt_val   (cnt_val),
        .gate      (gate),
        .rise      (rise),
        .cnt       (cnt),
        .ld        (ld),
        .ld_val    (ld_val),
        .dec       (dec),
        .bcd       (bcd),
        .out       (out)
    );

    pcc_counter u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ld     (ld),
        .ld_val (ld_val),
        .dec    (dec),
        .bcd    (bcd),
        .cnt    (cnt)
    );

    assign count = cnt;
endmodule

// File: tb/pcc_channel_tb.sv
`timescale 1ns/1ps
module pcc_channel_tb;
    logic        clk = 1'b0;
    logic        rst_n, ctrl_wr, ctrl_bcd, cnt_wr, gate;
    logic [2:0]  ctrl_mode;
    logic [15:0] cnt_val;
    logic        out;
    logic [15:0] count;
    int checks = 0;
    int errors = 0;

    pcc_channel u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_mode (ctrl_mode),
        .ctrl_bcd  (ctrl_bcd),
        .cnt_wr    (cnt_wr),
        .cnt_val   (cnt_val),
        .gate      (gate),
        .out       (out),
        .count     (count)
    );

    always #2.5 clk = ~clk;

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(logic [2:0] m, logic b);
        ctrl_mode = m; ctrl_bcd = b; ctrl_wr = 1'b1;
        step();
        ctrl_wr = 1'b0;
    endtask

    task automatic wr_cnt(logic [15:0] v);
        cnt_val = v; cnt_wr = 1'b1;
        step();
        cnt_wr = 1'b0;
    endtask

    // Mode 0 sweep: out = k>=n, count = n-k after the load edge.
    task automatic run_m0(int n);
        gate = 1'b1;
        wr_ctrl(3'd0, 1'b0);
        chk("R2 out low after control write", 16'(out), 16'd0);
        wr_cnt(16'(n));
        for (int k = 0; k <= n + 2; k++) begin
            chk("R2 mode0 out", 16'(out), 16'(k >= n));
            chk("R2 mode0 count", count, 16'(n - k));
            step();
        end
    endtask

    // Mode 4 sweep: one-clock low exactly at k == n.
    task automatic run_m4(int n);
        gate = 1'b1;
        wr_ctrl(3'd4, 1'b0);
        wr_cnt(16'(n));
        for (int k = 0; k <= n + 2; k++) begin
            chk("R9 mode4 out", 16'(out), 16'(k != n));
            step();
        end
    endtask

    // Periodic modes: count = n-(k mod n); square wave high while count > n/2.
    task automatic run_per(logic [2:0] m, int n, bit sq, string tag);
        gate = 1'b1;
        wr_ctrl(m, 1'b0);
        step();
        wr_cnt(16'(n));
        for (int k = 0; k <= 2 * n + 1; k++) begin
            int c;
            c = n - (k % n);
            chk(tag, count, 16'(c));
            chk(tag, 16'(out), sq ? 16'(c > n / 2) : 16'(c != 1));
            step();
        end
    endtask

    // Gate-triggered modes: trigger edge at k = 0.
    task automatic run_trig(logic [2:0] m, int n);
        gate = 1'b0;
        wr_ctrl(m, 1'b0);
        wr_cnt(16'(n));
        chk(m == 3'd1 ? "R5 out high before trigger" : "R10 out high before trigger", 16'(out), 16'd1);
        gate = 1'b1;
        step();
        for (int k = 0; k <= n + 2; k++) begin
            if (m == 3'd1) chk("R5 one-shot out", 16'(out), 16'(k >= n));
            else           chk("R10 hw strobe out", 16'(out), 16'(k != n));
            if (k <= n) chk(m == 3'd1 ? "R5 count" : "R10 count", count, 16'(n - k));
            step();
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; ctrl_wr = 1'b0; ctrl_mode = 3'd0; ctrl_bcd = 1'b0;
        cnt_wr = 1'b0; cnt_val = 16'd0; gate = 1'b0;
        @(negedge clk);
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset out", 16'(out), 16'd0);
        chk("R1 reset count", count, 16'd0);

        for (int n = 1; n <= 12; n++) run_m0(n);
        for (int n = 1; n <= 8; n++) run_m4(n);

        // R3: gate low holds mode 0 count
        wr_ctrl(3'd0, 1'b0); gate = 1'b1;
        wr_cnt(16'd5); step(); step();
        gate = 1'b0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk("R3 mode0 hold count", count, 16'd3);
            chk("R3 mode0 out", 16'(out), 16'd0);
        end
        gate = 1'b1;
        step(); step(); step();
        chk("R3 mode0 resumes", 16'(out), 16'd1);

        // R3: gate low holds mode 4 count
        wr_ctrl(3'd4, 1'b0); wr_cnt(16'd3); step();
        gate = 1'b0; step(); step();
        chk("R3 mode4 hold count", count, 16'd2);
        gate = 1'b1; step();
        chk("R3 mode4 resumed", count, 16'd1);
        step();
        chk("R3 mode4 strobe", 16'(out), 16'd0);

        // R4: rewrite during countdown restarts
        wr_ctrl(3'd0, 1'b0); wr_cnt(16'd8); step(); step(); step();
        wr_cnt(16'd4);
        chk("R4 reload count", count, 16'd4);
        chk("R4 reload out", 16'(out), 16'd0);
        step(); step(); step();
        chk("R4 still low", 16'(out), 16'd0);
        step();
        chk("R4 ends after new count", 16'(out), 16'd1);

        for (int n = 1; n <= 6; n++) run_trig(3'd1, n);
        for (int n = 1; n <= 6; n++) run_trig(3'd5, n);

        // R5: trigger before any count write is ignored
        gate = 1'b0; wr_ctrl(3'd1, 1'b0);
        gate = 1'b1; step(); step();
        chk("R5 no count no pulse", 16'(out), 16'd1);

        // R5: retrigger restarts full pulse
        gate = 1'b0; wr_ctrl(3'd1, 1'b0); wr_cnt(16'd6);
        gate = 1'b1; step(); step(); step();
        gate = 1'b0; step();
        chk("R5 pulse mid", count, 16'd3);
        gate = 1'b1; step();
        chk("R5 retrigger reload", count, 16'd6);
        for (int k = 0; k < 6; k++) begin
            chk("R5 retrigger low", 16'(out), 16'd0);
            step();
        end
        chk("R5 retrigger end", 16'(out), 16'd1);

        // R6: count written during pulse leaves it alone
        gate = 1'b0; wr_ctrl(3'd1, 1'b0); wr_cnt(16'd6);
        gate = 1'b1; step(); step();
        wr_cnt(16'd3);
        chk("R6 count unaffected", count, 16'd4);
        step(); step(); step();
        chk("R6 old pulse runs", 16'(out), 16'd0);
        step();
        chk("R6 old pulse ends", 16'(out), 16'd1);
        gate = 1'b0; step(); gate = 1'b1; step();
        chk("R6 new count used", count, 16'd3);
        step(); step();
        chk("R6 new pulse low", 16'(out), 16'd0);
        step();
        chk("R6 new pulse ends", 16'(out), 16'd1);

        for (int n = 2; n <= 7; n++) run_per(3'd2, n, 1'b0, "R7 rate");
        for (int n = 2; n <= 9; n++) run_per(3'd3, n, 1'b1, "R8 square");
        run_per(3'd6, 3, 1'b0, "R11 alias 6 as rate");
        run_per(3'd7, 5, 1'b1, "R11 alias 7 as square");

        // R7: gate low holds and forces high; rise reloads
        gate = 1'b1; wr_ctrl(3'd2, 1'b0); step(); wr_cnt(16'd4);
        step(); step();
        gate = 1'b0; step();
        chk("R7 gate low holds", count, 16'd2);
        chk("R7 gate low out high", 16'(out), 16'd1);
        gate = 1'b1; step();
        chk("R7 rise reloads", count, 16'd4);
        step();
        chk("R7 counting again", count, 16'd3);

        // R7: new count applies at next reload
        wr_ctrl(3'd2, 1'b0); step(); wr_cnt(16'd3); step();
        wr_cnt(16'd5);
        chk("R7 write keeps counting", count, 16'd1);
        chk("R7 low at one", 16'(out), 16'd0);
        step();
        chk("R7 reload new value", count, 16'd5);

        // R12: BCD decrement
        wr_ctrl(3'd0, 1'b1); wr_cnt(16'h0010); step();
        chk("R12 bcd 10 to 09", count, 16'h0009);
        wr_cnt(16'h1000); step();
        chk("R12 bcd 1000 to 0999", count, 16'h0999);
        wr_cnt(16'h0000); step();
        chk("R12 bcd 0 to 9999", count, 16'h9999);

        // R12: BCD square wave, eleven gives 6 high 5 low
        gate = 1'b1; wr_ctrl(3'd3, 1'b1); step(); wr_cnt(16'h0011);
        for (int k = 0; k < 11; k++) begin
            chk("R12 bcd square out", 16'(out), 16'(k < 6));
            step();
        end
        chk("R12 bcd square reload", count, 16'h0011);

        // R13: binary zero acts as 65536
        wr_ctrl(3'd0, 1'b0); wr_cnt(16'h0000); step();
        chk("R13 zero wraps", count, 16'hFFFF);
        chk("R13 out still low", 16'(out), 16'd0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule